// File: doc/BRIEF.md
# NOR Page Program Buffer with Page Wrap

This block sits behind the serial front end of a NOR flash model. A program command brings a start address and then a stream of data bytes. Each byte goes into a page-sized staging buffer at an index that starts at the low address bits and wraps inside the page. A per-byte flag records which slots were filled. When chip select rises on a byte boundary, the front end pulses a go signal. When it rises inside a byte, the front end pulses an abort.

A go starts a self-timed cycle. Busy stays high for a fixed number of clock cycles. At the end, every flagged byte is ANDed into the array, so bits can only change from 1 to 0. Done then pulses. Sector and block erase share the same busy/done cycle and fill the addressed region with FFh. Opcode decoding and protection checks are done elsewhere.

The data input is a valid/ready stream. A byte transfers on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` is low exactly while the block is busy. The sender does not need to hold a byte through back-pressure, because a real serial sender has no way to stall. Any byte offered while busy is discarded. The array is sized down by parameter for synthesis. The defaults are a 2 KB array, 256-byte pages, 512-byte sectors and 1 KB blocks.

Top module: `nor_page_prog_buf`

## Requirements
- R1: After reset, `busy`=0, `done`=0, `in_ready`=1, and every array byte reads FFh on `rd_data`.
- R2: `in_ready` is 0 in every cycle `busy` is 1. A byte offered while busy is not stored.
- R3: The first data byte after `addr_load` goes to the offset given by `addr_in[7:0]`. The offset increments per byte and wraps from FFh to 00h inside the same page, given by `addr_in[ADDR_W-1:8]`.
- R4: When more than 256 bytes are sent, each offset holds the last byte sent to it, so the last 256 bytes are the ones programmed.
- R5: A program cycle changes only the offsets that received a byte. All other array bytes keep their value.
- R6: Programming stores old AND new for each written byte, so no bit goes from 0 to 1.
- R7: `prog_abort` discards the collected bytes. No busy cycle starts, no `done` is raised, and the array is unchanged.
- R8: `prog_go` with no byte collected since the last `cmd_start` or abort starts no cycle. `busy` and `done` stay 0.
- R9: An accepted `prog_go` raises `busy` from the next cycle for BUSY_CYC cycles. The array update is visible and `done` is 1 for one cycle in the cycle after `busy` falls.
- R10: `cmd_start` clears all byte flags, so bytes from an earlier command are not programmed.
- R11: `erase_go` with `erase_blk`=0 sets the 2^SECTOR_W-byte region holding `addr_in` to FFh, with the R9 timing. All other bytes are unchanged.
- R12: `erase_go` with `erase_blk`=1 sets the 2^BLOCK_W-byte region holding `addr_in` to FFh, with the R9 timing.
- R13: While busy, `cmd_start`, `addr_load`, `prog_abort`, `prog_go` and `erase_go` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Pulse at the start of a new command; clears byte flags |
| addr_load | input | 1 | Latch `addr_in` as the page and start offset |
| addr_in | input | ADDR_W | Program start address or erase target address |
| in_valid | input | 1 | Data byte offered |
| in_ready | output | 1 | Block can take a byte (low while busy) |
| in_data | input | 8 | Data byte |
| prog_go | input | 1 | Chip select rose on a byte boundary: run the program cycle |
| prog_abort | input | 1 | Chip select rose inside a byte: discard the command |
| erase_go | input | 1 | Start an erase of the region holding `addr_in` |
| erase_blk | input | 1 | 0 = sector erase, 1 = block erase |
| busy | output | 1 | Self-timed cycle in progress |
| done | output | 1 | One-cycle pulse when a cycle has completed |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` (combinational) |

## Verification
A go or erase strobe driven in one cycle shows `busy` at the next falling-edge sample. `busy` is then seen for exactly BUSY_CYC samples. The sample after that shows `busy` low, `done` high and the new array contents, and the sample after that shows `done` low. The bench walks this schedule sample by sample and checks each step. Rejected strobes (abort, go with no bytes, anything driven while busy) are checked by watching BUSY_CYC+2 samples for no `busy` and no `done`. After every operation, the whole array is read through `rd_addr` while idle and compared against a shadow model built from the requirements.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_BLK  = 2'd3
  } ppb_op_e;
endpackage

// File: rtl/ppb_page_buf.sv
module ppb_page_buf #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     ld,
  input  logic [ADDR_W-1:0]        ld_addr,
  input  logic                     beat,
  input  logic [7:0]               beat_data,
  output logic [ADDR_W-1:PAGE_W]   page_q,
  output logic [7:0]               pbyte_q [2**PAGE_W],
  output logic [2**PAGE_W-1:0]     vld_q,
  output logic                     has_data
);
  localparam int PAGE_B = 2**PAGE_W;

  logic [PAGE_W-1:0] idx_q;

  assign has_data = |vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      vld_q  <= '0;
      page_q <= '0;
    end else begin
      if (clr) vld_q <= '0;
      if (ld) {page_q, idx_q} <= ld_addr;
      if (beat && !clr) begin
        vld_q[idx_q] <= 1'b1;
        idx_q        <= idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (beat && !clr) pbyte_q[idx_q] <= beat_data;
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !has_data); // R10

  AST_BEAT_FLAGS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !clr) |=> vld_q[$past(idx_q)]); // R3

  initial begin
    assert (PAGE_B >= 2) else $error("page too small");
  end
endmodule

// File: rtl/ppb_seq.sv
module ppb_seq
  import ppb_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int BUSY_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_go,
  input  logic              erase_go,
  input  logic              erase_blk,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic              has_data,
  output logic              busy,
  output logic              done,
  output logic              fire_prog,
  output logic              fire_sect,
  output logic              fire_blk,
  output logic [ADDR_W-1:0] tgt_addr
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  ppb_op_e           op_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic              last;

  assign busy      = (op_q != OP_NONE);
  assign last      = busy && (cnt_q == CNT_W'(BUSY_CYC - 1));
  assign fire_prog = last && (op_q == OP_PROG);
  assign fire_sect = last && (op_q == OP_SECT);
  assign fire_blk  = last && (op_q == OP_BLK);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_NONE;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      tgt_addr <= '0;
    end else begin
      done_q <= last;
      if (!busy) begin
        cnt_q <= '0;
        if (prog_go && has_data) begin
          op_q <= OP_PROG;
        end else if (erase_go) begin
          op_q     <= erase_blk ? OP_BLK : OP_SECT;
          tgt_addr <= go_addr;
        end
      end else if (last) begin
        op_q <= OP_NONE;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy)); // R9

  AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R9

  AST_EMPTY_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && prog_go && !has_data && !erase_go) |=> !busy); // R8

  AST_ONE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fire_prog, fire_sect, fire_blk})); // R9

  initial begin
    assert (BUSY_CYC >= 1) else $error("BUSY_CYC must be at least 1");
  end
endmodule

// File: rtl/ppb_array.sv
module ppb_array #(
  parameter int ADDR_W   = 11,
  parameter int PAGE_W   = 8,
  parameter int SECTOR_W = 9,
  parameter int BLOCK_W  = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fire_prog,
  input  logic                   fire_sect,
  input  logic                   fire_blk,
  input  logic [ADDR_W-1:0]      tgt_addr,
  input  logic [ADDR_W-1:PAGE_W] page,
  input  logic [7:0]             pbyte [2**PAGE_W],
  input  logic [2**PAGE_W-1:0]   vld,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [7:0]             rd_data
);
  localparam int DEPTH = 2**ADDR_W;

  logic [7:0] mem [DEPTH];

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (fire_prog && (ADDR_W'(i) >> PAGE_W) == ADDR_W'(page)
            && vld[i % (2**PAGE_W)]) begin
          mem[i] <= mem[i] & pbyte[i % (2**PAGE_W)];
        end else if (fire_sect && (ADDR_W'(i) >> SECTOR_W) == (tgt_addr >> SECTOR_W)) begin
          mem[i] <= 8'hFF;
        end else if (fire_blk && (ADDR_W'(i) >> BLOCK_W) == (tgt_addr >> BLOCK_W)) begin
          mem[i] <= 8'hFF;
        end
      end
    end
  end

  AST_NO_BIT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_addr) && !$past(fire_sect) && !$past(fire_blk))
      |-> ((rd_data & ~$past(rd_data)) == 8'h00)); // R6

  initial begin
    assert (PAGE_W <= SECTOR_W && SECTOR_W < BLOCK_W && BLOCK_W < ADDR_W)
      else $error("region widths out of order");
  end
endmodule

// File: rtl/nor_page_prog_buf.sv
module nor_page_prog_buf #(
  parameter int ADDR_W   = 11,
  parameter int PAGE_W   = 8,
  parameter int SECTOR_W = 9,
  parameter int BLOCK_W  = 10,
  parameter int BUSY_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              prog_go,
  input  logic              prog_abort,
  input  logic              erase_go,
  input  logic              erase_blk,
  output logic              busy,
  output logic              done,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic                   idle;
  logic                   clr;
  logic                   ld;
  logic                   beat;
  logic [ADDR_W-1:PAGE_W] page;
  logic [7:0]             pbyte [2**PAGE_W];
  logic [2**PAGE_W-1:0]   vld;
  logic                   has_data;
  logic                   fire_prog;
  logic                   fire_sect;
  logic                   fire_blk;
  logic [ADDR_W-1:0]      tgt_addr;

  assign idle     = !busy;
  assign in_ready = idle;
  assign clr      = (cmd_start || prog_abort) && idle;
  assign ld       = addr_load && idle;
  assign beat     = in_valid && idle;

  ppb_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .ld_addr(addr_in),
    .beat(beat), .beat_data(in_data), .page_q(page), .pbyte_q(pbyte),
    .vld_q(vld), .has_data(has_data)
  );

  ppb_seq #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go && !prog_abort),
    .erase_go(erase_go), .erase_blk(erase_blk), .go_addr(addr_in),
    .has_data(has_data), .busy(busy), .done(done), .fire_prog(fire_prog),
    .fire_sect(fire_sect), .fire_blk(fire_blk), .tgt_addr(tgt_addr)
  );

  ppb_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECTOR_W(SECTOR_W),
              .BLOCK_W(BLOCK_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .fire_prog(fire_prog), .fire_sect(fire_sect),
    .fire_blk(fire_blk), .tgt_addr(tgt_addr), .page(page), .pbyte(pbyte),
    .vld(vld), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  AST_ABORT_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && prog_abort && !erase_go) |=> !busy); // R7
endmodule

// File: tb/nor_page_prog_buf_tb_top.sv
module nor_page_prog_buf_tb_top;
  localparam int AW = 11;
  localparam int BC = 8;
  localparam int DEPTH = 2**AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 0, addr_load = 0, in_valid = 0, prog_go = 0;
  logic prog_abort = 0, erase_go = 0, erase_blk = 0;
  logic [AW-1:0] addr_in = '0, rd_addr = '0;
  logic [7:0] in_data = '0;
  logic in_ready, busy, done;
  logic [7:0] rd_data;

  logic [7:0] model [DEPTH];
  logic [7:0] pend [256];
  logic       sent [256];
  logic [7:0] widx;
  logic [AW-1:8] wpage;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  nor_page_prog_buf #(.ADDR_W(AW), .BUSY_CYC(BC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .addr_load(addr_load),
    .addr_in(addr_in), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .prog_go(prog_go), .prog_abort(prog_abort),
    .erase_go(erase_go), .erase_blk(erase_blk), .busy(busy), .done(done),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic scan(input string req);
    int mism = 0, fa = 0, fe = 0, faddr = 0;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a);
      #1;
      if (rd_data !== model[a]) begin
        if (mism == 0) begin fa = rd_data; fe = model[a]; faddr = a; end
        mism++;
      end
    end
    chk(mism == 0, req, $sformatf("array byte @%0h", faddr), fa, fe);
    @(negedge clk);
  endtask

  task automatic start_cmd(input int a);
    cmd_start = 1;
    @(negedge clk);
    cmd_start = 0; addr_load = 1; addr_in = AW'(a);
    @(negedge clk);
    addr_load = 0;
    for (int o = 0; o < 256; o++) sent[o] = 0;
    widx = a[7:0];
    wpage = a[AW-1:8];
  endtask

  task automatic send_byte(input logic [7:0] d);
    in_valid = 1; in_data = d;
    @(negedge clk);
    in_valid = 0;
    pend[widx] = d; sent[widx] = 1; widx = widx + 1;
  endtask

  task automatic commit_model();
    for (int o = 0; o < 256; o++)
      if (sent[o]) model[{wpage, 8'(o)}] = model[{wpage, 8'(o)}] & pend[o];
  endtask

  task automatic wait_busy(input string req, input bit inject);
    bit ok = 1;
    for (int i = 1; i <= BC; i++) begin
      if (i > 1) @(negedge clk);
      if (!busy || done) ok = 0;
      if (inject && i == 1) begin
        chk(in_ready == 0, "R2", "in_ready while busy", in_ready, 0);
        in_valid = 1; in_data = 8'h00; cmd_start = 1; addr_load = 1;
        addr_in = 11'h010; erase_go = 1; erase_blk = 1; prog_abort = 1;
      end
      if (inject && i == 2) begin
        in_valid = 0; cmd_start = 0; addr_load = 0; erase_go = 0;
        erase_blk = 0; prog_abort = 0;
      end
    end
    chk(ok, req, "busy window", busy, 1);
    @(negedge clk);
    chk(done && !busy, req, "done after busy", {busy, done}, 1);
    @(negedge clk);
    chk(!done, req, "done single pulse", done, 0);
  endtask

  task automatic expect_idle(input string req);
    bit ok = 1;
    for (int i = 0; i < BC + 2; i++) begin
      if (busy || done) ok = 0;
      @(negedge clk);
    end
    chk(ok, req, "no cycle started", {busy, done}, 0);
  endtask

  task automatic go(input string req, input bit runs);
    prog_go = 1;
    @(negedge clk);
    prog_go = 0;
    if (runs) begin wait_busy(req, 0); commit_model(); end
    else expect_idle(req);
  endtask

  task automatic do_erase(input string req, input bit blk, input int a);
    int w = blk ? 10 : 9;
    erase_go = 1; erase_blk = blk; addr_in = AW'(a);
    @(negedge clk);
    erase_go = 0; erase_blk = 0;
    wait_busy(req, 0);
    for (int i = 0; i < DEPTH; i++) if ((i >> w) == (a >> w)) model[i] = 8'hFF;
    scan(req);
  endtask

  task automatic t_reset();
    chk(!busy && !done && in_ready, "R1", "reset flags", {busy, done, in_ready}, 1);
    scan("R1");
  endtask

  task automatic t_short();   // R5, R9
    start_cmd(11'h105);
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h00); send_byte(8'h7E);
    go("R9", 1);
    scan("R5");
  endtask

  task automatic t_wrap();    // R3
    start_cmd(11'h2FC);
    for (int j = 0; j < 8; j++) send_byte(8'(8'h10 + j));
    go("R3", 1);
    scan("R3");
  endtask

  task automatic t_over();    // R4
    start_cmd(11'h310);
    for (int j = 0; j < 300; j++) send_byte(8'(j) ^ 8'h5A);
    go("R4", 1);
    scan("R4");
  endtask

  task automatic t_and();     // R6
    start_cmd(11'h105);
    send_byte(8'h0F); send_byte(8'hFF);
    go("R6", 1);
    rd_addr = 11'h105; #1;
    chk(rd_data == 8'h05, "R6", "AND result", rd_data, 8'h05);
    @(negedge clk);
    scan("R6");
  endtask

  task automatic t_abort();   // R7
    start_cmd(11'h600);
    send_byte(8'h12); send_byte(8'h34); send_byte(8'h56);
    prog_abort = 1;
    @(negedge clk);
    prog_abort = 0;
    expect_idle("R7");
    go("R7", 0);
    scan("R7");
  endtask

  task automatic t_empty();   // R8
    start_cmd(11'h680);
    go("R8", 0);
    scan("R8");
  endtask

  task automatic t_restart(); // R10
    start_cmd(11'h700);
    for (int j = 0; j < 5; j++) send_byte(8'h00);
    start_cmd(11'h7A0);
    send_byte(8'hC3);
    go("R10", 1);
    scan("R10");
  endtask

  task automatic t_busy_ignore(); // R2, R13
    start_cmd(11'h500);
    send_byte(8'h81); send_byte(8'h42);
    prog_go = 1;
    @(negedge clk);
    prog_go = 0;
    wait_busy("R13", 1);
    commit_model();
    expect_idle("R13");
    scan("R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    @(posedge rst_n);
    @(negedge clk);
    t_reset();
    t_short();
    t_wrap();
    t_over();
    t_and();
    t_abort();
    t_empty();
    t_restart();
    t_busy_ignore();
    do_erase("R11", 0, 11'h305);
    do_erase("R12", 1, 11'h405);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule